// File: doc/BRIEF.md
# Pull-Value Frame Write Sequencer

This block sits on the host side of a digitally pulled oscillator. It takes a signed pull request, already converted to a two's-complement code, and turns it into one or two 40-bit serial write frames. A line encoder downstream turns each bit into the analog signalling. Each frame has a fixed 16-bit header, then an 8-bit register select, then a 16-bit data word. The header holds a 4-bit device address nibble set by a parameter. Bits leave the block one at a time, most significant first, under a valid/ready handshake.

In narrow mode a single frame carries a 16-bit code. In wide mode a 23-bit code is split across two frames, and the low part is always sent first. The oscillator acts only on the second frame, so this order matters. After every frame the sequencer keeps the line quiet for a parameterised number of clock cycles. It holds `busy` until that quiet time after the final frame has run out. The mode and the code are captured when a request is accepted. Requests that arrive while busy are dropped.

Top module: `pull_frame_seq`

## Requirements
- R1: Every frame is 40 bits, sent most significant bit first. It is the header {8'hFA, DEV_ADDR[3:0], 4'hA}, then the 8-bit register select, then the 16-bit data word.
- R2: With `mode_wide`=0 exactly one frame is sent. Its register select is 8'h06 and its data is `pull_value[15:0]`. Bits 22:16 of `pull_value` have no effect on it.
- R3: With `mode_wide`=1 exactly two frames are sent, always in this order. The first has register select 8'h07 and data {9'b0, `pull_value[6:0]`}. The second has register select 8'h06 and data `pull_value[22:7]`. For example, 23'h09CF8A gives tails 07000A and then 06139F.
- R4: A bit is transferred at a rising edge where `ser_valid` and `ser_ready` are both high. While `ser_valid` is high and `ser_ready` is low, `ser_valid` stays high and `ser_bit` holds its value.
- R5: Between the last bit transfer of one frame and the first bit of the next frame, `ser_valid` is low for exactly GAP_CYCLES+1 cycles. After the final frame, `busy` falls at the GAP_CYCLES-th rising edge after the last bit transfer edge.
- R6: `start` is accepted only while `busy` is low, and `busy` is high from the next edge on. `ser_valid` stays low in the first busy cycle. A `start` seen while `busy` is high is ignored.
- R7: The mode and the pull value are captured at the accepting edge. Later changes on `mode_wide` or `pull_value` do not alter the frames in progress.
- R8: `done` is high for exactly one cycle per request. That cycle is the one right after the final frame's last bit transfer edge, and `ser_valid` is low in it.
- R9: While `rst_n` is low at a rising edge, `busy`, `ser_valid` and `done` go low. A frame in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, taken when not busy |
| mode_wide | input | 1 | 0: one 16-bit frame, 1: 23-bit value over two frames |
| pull_value | input | 23 | Two's-complement pull code (narrow mode uses bits 15:0) |
| ser_bit | output | 1 | Current serial bit |
| ser_valid | output | 1 | ser_bit is valid |
| ser_ready | input | 1 | Line encoder accepts the bit at this edge |
| busy | output | 1 | A request is in progress, including the trailing gap |
| done | output | 1 | One-cycle pulse after the final bit of a request |

## Verification
The bound checker watches, on every cycle, the handshake hold under back-pressure and that `ser_valid` appears only inside `busy`. It also checks that the first busy cycle is quiet, that start is accepted from idle, and that `done` is a single pulse falling in a quiet cycle. Only the bench scenarios can show the rest. That covers the frame contents and their low-then-high order for narrow, wide, extreme and negative codes, and the exact quiet-gap lengths. It also covers the dropping of requests made mid-frame or mid-gap, the capture of inputs at acceptance, and abandonment of a frame on reset.

// File: rtl/pfs_pkg.sv
// Shared constants, state type and frame packing for the pull-frame sequencer.
// Assumes the fixed 40-bit frame layout: header, register select, data word.
package pfs_pkg;
    localparam int HDR_BITS   = 16;
    localparam int SEL_BITS   = 8;
    localparam int DATA_BITS  = 16;
    localparam int FRAME_BITS = HDR_BITS + SEL_BITS + DATA_BITS;
    localparam int WIDE_BITS  = 23;
    localparam int FINE_BITS  = WIDE_BITS - DATA_BITS;
    localparam int FINE_PAD   = DATA_BITS - FINE_BITS;

    localparam logic [SEL_BITS-1:0] SEL_COARSE = 8'h06;
    localparam logic [SEL_BITS-1:0] SEL_FINE   = 8'h07;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SEND,
        ST_GAP
    } seq_state_t;

    // Build one frame from the address nibble, register select and data word.
    function automatic logic [FRAME_BITS-1:0] pack_frame(
        input logic [3:0]           addr,
        input logic [SEL_BITS-1:0]  sel,
        input logic [DATA_BITS-1:0] data
    );
        return {8'hFA, addr, 4'hA, sel, data};
    endfunction
endpackage

// File: rtl/pfs_word_split.sv
// Chooses the register select and data word for the frame about to be sent.
// Assumes fine_phase is only ever set when wide mode was captured.
module pfs_word_split
    import pfs_pkg::*;
(
    input  logic                 wide,
    input  logic                 fine_phase,
    input  logic [WIDE_BITS-1:0] value,
    output logic [SEL_BITS-1:0]  sel,
    output logic [DATA_BITS-1:0] data
);
    // Pick the low-part, high-part or narrow word.
    always_comb begin
        if (wide && fine_phase) begin
            sel  = SEL_FINE;
            data = {{FINE_PAD{1'b0}}, value[FINE_BITS-1:0]};
        end else if (wide) begin
            sel  = SEL_COARSE;
            data = value[WIDE_BITS-1:FINE_BITS];
        end else begin
            sel  = SEL_COARSE;
            data = value[DATA_BITS-1:0];
        end
    end
endmodule

// File: rtl/pfs_shifter.sv
// MSB-first parallel-to-serial shifter with a transfer counter.
// Assumes load and advance are never high in the same cycle.
module pfs_shifter #(
    parameter int WIDTH = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] din,
    input  logic             advance,
    output logic             dout,
    output logic             last
);
    localparam int CW = $clog2(WIDTH);

    logic [WIDTH-1:0] sh_q;
    logic [CW-1:0]    cnt_q;

    // Load a new frame or shift out one bit per transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            sh_q  <= din;
            cnt_q <= '0;
        end else if (advance) begin
            sh_q  <= {sh_q[WIDTH-2:0], 1'b0};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign dout = sh_q[WIDTH-1];
    assign last = (cnt_q == CW'(WIDTH - 1));
endmodule

// File: rtl/pfs_gap_timer.sv
// Down-counter that measures the quiet time after each frame.
// Assumes GAP >= 1; expired is meaningful only once the counter has been armed.
module pfs_gap_timer #(
    parameter int GAP = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic expired
);
    localparam int CW = (GAP < 2) ? 1 : $clog2(GAP + 1);

    logic [CW-1:0] cnt_q;

    // Reload on arm, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (arm) begin
            cnt_q <= CW'(GAP - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/pull_frame_seq.sv
// Pull-value frame write sequencer: captures a request and emits one or two
// 40-bit frames over a valid/ready bit handshake, with a quiet gap after each.
// Assumes GAP_CYCLES >= 1 and a downstream encoder that eventually raises ready.
module pull_frame_seq
    import pfs_pkg::*;
#(
    parameter logic [3:0] DEV_ADDR   = 4'h0,
    parameter int         GAP_CYCLES = 100
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 mode_wide,
    input  logic [WIDE_BITS-1:0] pull_value,
    output logic                 ser_bit,
    output logic                 ser_valid,
    input  logic                 ser_ready,
    output logic                 busy,
    output logic                 done
);
    seq_state_t           state_q;
    logic                 wide_q;
    logic [WIDE_BITS-1:0] value_q;
    logic                 fine_q;
    logic                 more_q;
    logic                 done_q;

    logic [SEL_BITS-1:0]  cur_sel;
    logic [DATA_BITS-1:0] cur_data;
    logic                 xfer;
    logic                 last_bit;
    logic                 frame_end;
    logic                 gap_over;

    assign ser_valid = (state_q == ST_SEND);
    assign busy      = (state_q != ST_IDLE);
    assign done      = done_q;
    assign xfer      = ser_valid && ser_ready;
    assign frame_end = xfer && last_bit;

    pfs_word_split u_split (
        .wide       (wide_q),
        .fine_phase (fine_q),
        .value      (value_q),
        .sel        (cur_sel),
        .data       (cur_data)
    );

    pfs_shifter #(.WIDTH(FRAME_BITS)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (state_q == ST_LOAD),
        .din     (pack_frame(DEV_ADDR, cur_sel, cur_data)),
        .advance (xfer),
        .dout    (ser_bit),
        .last    (last_bit)
    );

    pfs_gap_timer #(.GAP(GAP_CYCLES)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (frame_end),
        .expired (gap_over)
    );

    // Request sequencing: accept, load, send, wait out the gap, repeat or finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wide_q  <= 1'b0;
            value_q <= '0;
            fine_q  <= 1'b0;
            more_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        wide_q  <= mode_wide;
                        value_q <= pull_value;
                        fine_q  <= mode_wide;
                        state_q <= ST_LOAD;
                    end
                end
                ST_LOAD: state_q <= ST_SEND;
                ST_SEND: begin
                    if (frame_end) begin
                        more_q  <= fine_q;
                        done_q  <= !fine_q;
                        fine_q  <= 1'b0;
                        state_q <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (gap_over) begin
                        state_q <= more_q ? ST_LOAD : ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pfs_checks.sv
// Port-level protocol checker for pull_frame_seq, attached by bind below.
module pfs_checks (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic ser_bit,
    input logic ser_valid,
    input logic ser_ready,
    input logic busy,
    input logic done
);
    // R4: a stalled bit stays offered and unchanged
    p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_valid && !ser_ready) |=> (ser_valid && $stable(ser_bit)));

    // R6: bits are offered only inside a busy window
    p_valid_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ser_valid |-> busy);

    // R6: a start from idle is taken at once
    p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R6: the first busy cycle carries no bit
    p_first_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !ser_valid);

    // R8: done lasts a single cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: done falls in a quiet, still-busy cycle
    p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && !ser_valid));
endmodule

bind pull_frame_seq pfs_checks u_pfs_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ser_bit   (ser_bit),
    .ser_valid (ser_valid),
    .ser_ready (ser_ready),
    .busy      (busy),
    .done      (done)
);

// File: tb/tb_pull_frame_seq.sv
// Self-checking bench: a vector table walked by one loop, then directed cases.
module tb_pull_frame_seq;
    localparam int         GAP  = 12;
    localparam logic [3:0] ADDR = 4'h3;
    localparam logic [15:0] HDR = {8'hFA, ADDR, 4'hA};

    typedef struct packed {
        logic        wide;
        logic [22:0] val;
        logic [23:0] t0;
        logic [23:0] t1;
        logic        bp;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 23'h09CF8A, 24'h07000A, 24'h06139F, 1'b0},
        '{1'b1, 23'h7FFFFF, 24'h07007F, 24'h06FFFF, 1'b1},
        '{1'b1, 23'h400000, 24'h070000, 24'h068000, 1'b0},
        '{1'b0, 23'h001234, 24'h061234, 24'h000000, 1'b0},
        '{1'b0, 23'h7F5A5A, 24'h065A5A, 24'h000000, 1'b1},
        '{1'b0, 23'h008001, 24'h068001, 24'h000000, 1'b0},
        '{1'b1, 23'h5ECC0B, 24'h07000B, 24'h06BD98, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mode_wide = 1'b0;
    logic [22:0] pull_value = '0;
    logic        ser_ready = 1'b1;
    logic        ser_bit, ser_valid, busy, done;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // monitor state
    int          negcnt = 0, bitcnt = 0, nfr = 0, lowcnt = 0, gap_meas = -1;
    int          last_neg = 0, done_cnt = 0, done_neg = 0, idle_neg = 0, stall_err = 0;
    logic [39:0] cap = '0;
    logic [39:0] frames [2];
    logic        prev_stall = 0, prev_bit = 0, prev_busy = 0, bp_en = 0;
    logic [7:0]  lfsr = 8'hA5;

    pull_frame_seq #(.DEV_ADDR(ADDR), .GAP_CYCLES(GAP)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_wide(mode_wide),
        .pull_value(pull_value), .ser_bit(ser_bit), .ser_valid(ser_valid),
        .ser_ready(ser_ready), .busy(busy), .done(done)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        bitcnt = 0; nfr = 0; lowcnt = 0; gap_meas = -1; done_cnt = 0;
        done_neg = 0; last_neg = 0; idle_neg = 0; stall_err = 0;
        frames[0] = '0; frames[1] = '0; prev_stall = 0;
    endtask

    // Sink model: set ready for the coming edge, then record the transfer.
    always @(negedge clk) begin
        negcnt++;
        if (!rst_n) begin
            prev_stall = 0;
            prev_busy  = 0;
        end else begin
            if (prev_stall && !(ser_valid && ser_bit == prev_bit)) stall_err++;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            ser_ready = bp_en ? lfsr[0] : 1'b1;
            if (busy && !ser_valid) lowcnt++;
            if (ser_valid && ser_ready) begin
                if (bitcnt == 0 && nfr > 0) gap_meas = lowcnt;
                cap = {cap[38:0], ser_bit};
                bitcnt++;
                if (bitcnt == 40) begin
                    if (nfr < 2) frames[nfr] = cap;
                    nfr++;
                    bitcnt = 0;
                    lowcnt = 0;
                    last_neg = negcnt;
                end
            end
            if (done) begin
                done_cnt++;
                done_neg = negcnt;
            end
            if (prev_busy && !busy) idle_neg = negcnt;
            prev_stall = ser_valid && !ser_ready;
            prev_bit   = ser_bit;
            prev_busy  = busy;
        end
    end

    task automatic run_vec(input vec_t v, input int poke);
        int nexp;
        @(negedge clk);
        clear_mon();
        bp_en = v.bp;
        start = 1'b1; mode_wide = v.wide; pull_value = v.val;
        @(negedge clk);
        start = 1'b0; mode_wide = ~v.wide; pull_value = ~v.val;
        chk(busy == 1'b1, "R6 busy after accept", 64'(busy), 64'd1);
        for (int k = 0; k < 20000; k++) begin
            if (!busy && done_cnt > 0) break;
            @(negedge clk);
            if (k == poke) begin
                start = 1'b1; mode_wide = 1'b0; pull_value = 23'h0055AA;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        @(negedge clk);
        nexp = v.wide ? 2 : 1;
        chk(nfr == nexp, "R2 R3 R6 frame count", 64'(nfr), 64'(nexp));
        chk(frames[0] == {HDR, v.t0}, "R1 R2 R3 R7 first frame", 64'(frames[0]), 64'({HDR, v.t0}));
        if (v.wide) begin
            chk(frames[1] == {HDR, v.t1}, "R1 R3 R7 second frame", 64'(frames[1]), 64'({HDR, v.t1}));
            chk(gap_meas == GAP + 1, "R5 inter-frame gap", 64'(gap_meas), 64'(GAP + 1));
        end
        chk(idle_neg - last_neg == GAP + 1, "R5 busy release", 64'(idle_neg - last_neg), 64'(GAP + 1));
        chk(done_cnt == 1, "R8 done pulse count", 64'(done_cnt), 64'd1);
        chk(done_neg == last_neg + 1, "R8 done timing", 64'(done_neg), 64'(last_neg + 1));
        if (v.bp) chk(stall_err == 0, "R4 stall hold", 64'(stall_err), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=hang exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: idle outputs after reset
        chk(busy == 0 && ser_valid == 0 && done == 0, "R9 reset state",
            64'({busy, ser_valid, done}), 64'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], -1);

        // R6: start pulses during a frame and during the gap are ignored
        run_vec(VECS[0], 10);
        run_vec(VECS[0], 46);
        // R6 R7: narrow request disturbed mid-frame
        run_vec(VECS[3], 20);

        // R9: reset in the middle of a frame abandons it
        @(negedge clk);
        clear_mon();
        bp_en = 0;
        start = 1'b1; mode_wide = 1'b1; pull_value = 23'h123456;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(busy == 0 && ser_valid == 0 && done == 0, "R9 reset mid-frame",
            64'({busy, ser_valid, done}), 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy == 0 && ser_valid == 0, "R9 stays idle after reset",
            64'({busy, ser_valid}), 64'd0);
        run_vec(VECS[5], -1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule